// File: doc/BRIEF.md
# Gated Muxed Two-Stage Clock Divider

This block turns one of four source clocks into a slower module clock under the control of a single 32-bit configuration word. Every source is modelled as a one-cycle tick on the fast system clock. The word chooses the source, gates the output on or off, and sets two divide stages. The first stage is a power-of-two prescaler. The second stage divides by an integer. The total period is R = 2^p * (m+1) source ticks, so the output rate is always the source rate or lower.

The divider drives two registered outputs. The first is a divided clock level with a near-50% duty cycle. The second is a one-cycle enable that marks the start of each output period. A new select, prescale or divide value is held back until the current output period has finished. This means a rewrite in the middle of a period never shortens or stretches a pulse that is already under way.

Top module: `modclk_gen`

## Requirements
- R1: Only bits 31, 25:24, 17:16 and 3:0 of the configuration word are stored. Every other bit reads back as zero, and writes to those bits have no effect. A write of all ones therefore reads back as 0x8303000F.
- R2: Reset clears the stored word. After reset the block selects source 0 with ratio 1, the gate is off, and both outputs are low.
- R3: Bits [25:24] pick which source tick input drives the divider. Ticks on the other three inputs have no effect on the outputs.
- R4: Bits [3:0] hold m. The linear stage divides by m+1, which gives 1 to 16.
- R5: Bits [17:16] hold p. The prescaler divides by 2^p, and one output period spans 2^p*(m+1) selected source ticks.
- R6: `div_tick` pulses for one cycle for the first source tick of each period. The number of pulses never exceeds the number of source ticks.
- R7: Within a period, `div_clk` is high for the first ceil(R/2) source ticks and low for the rest. With R=1, `div_clk` stays high.
- R8: When bit 31 is clear, both outputs go low on the next cycle and the period restarts. After the gate is set again, the next selected tick begins a new period.
- R9: A change to select, p or m takes effect at the next period start. The period in progress completes with the old settings.
- R10: Both outputs are registered. They respond one cycle after a selected tick. With the gate on and no selected tick, `div_clk` holds its value and `div_tick` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Stored configuration word, with unused bits reading as zero |
| src_tick | input | 4 | One tick enable per source clock |
| div_clk | output | 1 | Divided clock level |
| div_tick | output | 1 | One-cycle pulse at the start of each output period |

## Verification
The sweep covers every combination of prescale and linear divide. The selected source ticks on an irregular two-in-three pattern, and the unselected sources tick in exactly the gaps. Any use of the wrong source therefore breaks both the duty and the period count. Comparing odd and even ratios separates a correct ceiling rule for the high phase from a floor rule. Ratio 1 confirms that the output is held high. Directed sequences rewrite the divide fields and the source select in the middle of a period, and drop the gate mid-period. These show whether the old period finishes intact and whether the restart lands on the next tick.

// File: rtl/modclk_pkg.sv
package modclk_pkg;
  localparam int CFG_W    = 32;
  localparam int M_W      = 4;
  localparam int M_LSB    = 0;
  localparam int P_W      = 2;
  localparam int P_LSB    = 16;
  localparam int SEL_W    = 2;
  localparam int SEL_LSB  = 24;
  localparam int GATE_BIT = 31;

  typedef struct packed {
    logic             gate;
    logic [SEL_W-1:0] sel;
    logic [P_W-1:0]   p;
    logic [M_W-1:0]   m;
  } cfg_t;
endpackage

// File: rtl/modclk_cfg_reg.sv
module modclk_cfg_reg
  import modclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output cfg_t             cfg,
  output logic [CFG_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (wr_en) begin
      cfg.gate <= wr_data[GATE_BIT];
      cfg.sel  <= wr_data[SEL_LSB +: SEL_W];
      cfg.p    <= wr_data[P_LSB +: P_W];
      cfg.m    <= wr_data[M_LSB +: M_W];
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[GATE_BIT]          = cfg.gate;
    rd_data[SEL_LSB +: SEL_W]  = cfg.sel;
    rd_data[P_LSB +: P_W]      = cfg.p;
    rd_data[M_LSB +: M_W]      = cfg.m;
  end

  // R2: a cycle after reset the stored word is empty
  assert_reset_clears_R2: assert property (@(posedge clk)
    $past(rst) |-> (rd_data == '0));
endmodule

// File: rtl/modclk_src_sel.sv
module modclk_src_sel #(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = 2
) (
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [SEL_W-1:0]   sel,
  output logic               tick
);
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit[g] = src_tick[g] && (sel == SEL_W'(g));
  end

  assign tick = |hit;
endmodule

// File: rtl/modclk_divider.sv
module modclk_divider #(
  parameter int M_W   = 4,
  parameter int P_W   = 2,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate,
  input  logic [M_W-1:0]   cfg_m,
  input  logic [P_W-1:0]   cfg_p,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             tick,
  output logic [SEL_W-1:0] eff_sel,
  output logic             div_clk,
  output logic             div_tick
);
  localparam int PC_W = (1 << P_W) - 1;
  localparam int RW   = M_W + PC_W + 1;

  logic [PC_W-1:0]  pc;
  logic [M_W-1:0]   lc;
  logic [M_W-1:0]   m_a;
  logic [P_W-1:0]   p_a;
  logic [SEL_W-1:0] sel_a;

  logic             at_start;
  logic [M_W-1:0]   e_m;
  logic [P_W-1:0]   e_p;
  logic [RW-1:0]    ratio, half, pos;
  logic [PC_W-1:0]  pre_max;
  logic             pre_last, lin_last;

  assign at_start = (pc == '0) && (lc == '0);
  assign e_m      = at_start ? cfg_m   : m_a;
  assign e_p      = at_start ? cfg_p   : p_a;
  assign eff_sel  = at_start ? cfg_sel : sel_a;

  assign ratio    = (RW'(e_m) + RW'(1)) << e_p;
  assign half     = (ratio + RW'(1)) >> 1;
  assign pos      = (RW'(lc) << e_p) + RW'(pc);
  assign pre_max  = PC_W'((RW'(1) << e_p) - RW'(1));
  assign pre_last = (pc == pre_max);
  assign lin_last = (lc == e_m);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0; lc <= '0;
      m_a <= '0; p_a <= '0; sel_a <= '0;
      div_clk <= 1'b0; div_tick <= 1'b0;
    end else begin
      if (at_start) begin
        m_a <= cfg_m; p_a <= cfg_p; sel_a <= cfg_sel;
      end
      if (!gate) begin
        pc <= '0; lc <= '0;
        div_clk <= 1'b0; div_tick <= 1'b0;
      end else if (tick) begin
        div_tick <= at_start;
        div_clk  <= (pos < half);
        if (pre_last) begin
          pc <= '0;
          lc <= lin_last ? '0 : lc + 1'b1;
        end else begin
          pc <= pc + 1'b1;
        end
      end else begin
        div_tick <= 1'b0;
      end
    end
  end

  assert_gate_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !gate |=> (!div_clk && !div_tick));
  assert_tick_from_source_R6: assert property (@(posedge clk) disable iff (rst)
    div_tick |-> $past(tick && gate));
  assert_period_start_high_R7: assert property (@(posedge clk) disable iff (rst)
    div_tick |-> div_clk);
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (gate && !tick) |=> ($stable(div_clk) && !div_tick));
  assert_settings_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    !at_start |=> ($stable(m_a) && $stable(p_a) && $stable(sel_a)));
  assert_position_bound_R5: assert property (@(posedge clk) disable iff (rst)
    pos < ratio);
endmodule

// File: rtl/modclk_gen.sv
module modclk_gen
  import modclk_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [CFG_W-1:0]   cfg_rdata,
  input  logic [NUM_SRC-1:0] src_tick,
  output logic               div_clk,
  output logic               div_tick
);
  cfg_t             cfg;
  logic [SEL_W-1:0] eff_sel;
  logic             sel_tick;

  modclk_cfg_reg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .cfg     (cfg),
    .rd_data (cfg_rdata)
  );

  modclk_src_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
    .src_tick (src_tick),
    .sel      (eff_sel),
    .tick     (sel_tick)
  );

  modclk_divider #(.M_W(M_W), .P_W(P_W), .SEL_W(SEL_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .gate     (cfg.gate),
    .cfg_m    (cfg.m),
    .cfg_p    (cfg.p),
    .cfg_sel  (cfg.sel),
    .tick     (sel_tick),
    .eff_sel  (eff_sel),
    .div_clk  (div_clk),
    .div_tick (div_tick)
  );
endmodule

// File: tb/modclk_gen_tb.sv
module modclk_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [3:0]  src_tick = '0;
  logic        div_clk, div_tick;

  modclk_gen u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .src_tick(src_tick),
    .div_clk(div_clk), .div_tick(div_tick)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int k = 0, ract = 1, sel_a = 0;
  int pm = 0, pp = 0, psel = 0;
  bit pgate = 1'b0, exp_clk = 1'b0, exp_tick = 1'b0;
  string tag = "R10";
  int n_src = 0, n_out = 0;

  function automatic logic [31:0] cw(bit g, int s, int p, int m);
    return {g, 5'b0, 2'(s), 6'b0, 2'(p), 12'b0, 4'(m)};
  endfunction

  function automatic void model(logic [3:0] s);
    int se;
    if (!pgate) begin
      k = 0; exp_clk = 1'b0; exp_tick = 1'b0;
    end else begin
      se = (k == 0) ? psel : sel_a;
      if (k == 0) begin ract = (pm + 1) << pp; sel_a = psel; end
      if (s[se]) begin
        n_src++;
        exp_tick = (k == 0);
        exp_clk  = (k < (ract + 1) / 2);
        k = (k + 1) % ract;
      end else begin
        exp_tick = 1'b0;
      end
    end
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic compare();
    if (div_tick) n_out++;
    chk(div_tick == exp_tick, {tag, " div_tick"}, div_tick, exp_tick);
    chk(div_clk == exp_clk, {tag, " div_clk"}, div_clk, exp_clk);
  endtask

  task automatic step(logic [3:0] s);
    src_tick = s; cfg_we = 1'b0;
    model(s);
    @(negedge clk);
    compare();
  endtask

  task automatic wr(logic [31:0] d);
    cfg_we = 1'b1; cfg_wdata = d; src_tick = '0;
    model(4'b0);
    @(negedge clk);
    cfg_we = 1'b0;
    compare();
    pm = int'(d[3:0]); pp = int'(d[17:16]); psel = int'(d[25:24]); pgate = d[31];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2: cleared register and quiet outputs
    chk(cfg_rdata == 32'h0, "R2 rdata", int'(cfg_rdata), 0);
    chk(!div_clk && !div_tick, "R2 outputs", int'({div_clk, div_tick}), 0);
    tag = "R2";
    for (int i = 0; i < 4; i++) step(4'hF);

    // R1: reserved bits ignored
    wr(32'hFFFF_FFFF);
    chk(cfg_rdata == 32'h8303_000F, "R1 readback", int'(cfg_rdata), 32'h8303_000F);
    wr(32'h7CFC_FFF0);
    chk(cfg_rdata == 32'h0, "R1 reserved", int'(cfg_rdata), 0);

    // R3 R4 R5 R6 R7 R10: full sweep of p and m
    tag = "R3 R4 R5 R6 R7 R10";
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 16; m++) begin
        int sel, r, cnt;
        sel = (p * 16 + m) % 4;
        r = (m + 1) << p;
        wr(cw(1'b0, sel, p, m));
        wr(cw(1'b1, sel, p, m));
        n_src = 0; n_out = 0; cnt = 0;
        for (int c = 0; c < 3 * r + 4; c++) begin
          logic [3:0] s;
          bit on;
          on = (c % 3) != 1;
          s = on ? 4'b0 : 4'hF;
          s[sel] = on;
          step(s);
          cnt++;
        end
        // R6: exactly one start pulse per begun period
        chk(n_out == (n_src + r - 1) / r, "R6 period count", n_out, (n_src + r - 1) / r);
        chk(n_out <= n_src, "R6 rate bound", n_out, n_src);
      end
    end

    // R8: gate off quiets outputs even with ticks
    tag = "R8";
    wr(cw(1'b0, 0, 1, 7));
    wr(cw(1'b1, 0, 1, 7));
    for (int i = 0; i < 5; i++) step(4'b0001);
    wr(cw(1'b0, 0, 1, 7));
    for (int i = 0; i < 4; i++) step(4'hF);
    chk(!div_clk && !div_tick, "R8 gated", int'({div_clk, div_tick}), 0);
    wr(cw(1'b1, 0, 1, 7));
    for (int i = 0; i < 20; i++) step(4'b0001);

    // R9: divide change mid period
    tag = "R9";
    wr(cw(1'b0, 0, 0, 5));
    wr(cw(1'b1, 0, 0, 5));
    for (int i = 0; i < 3; i++) step(4'b0001);
    wr(cw(1'b1, 0, 1, 1));
    for (int i = 0; i < 14; i++) step(4'b0001);

    // R3 with R9: select change mid period
    tag = "R3 R9";
    wr(cw(1'b0, 0, 0, 3));
    wr(cw(1'b1, 0, 0, 3));
    for (int i = 0; i < 2; i++) step(4'b0001);
    wr(cw(1'b1, 2, 0, 3));
    for (int i = 0; i < 5; i++) step(4'b0001);
    for (int i = 0; i < 10; i++) step(4'b0100);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule